// File: doc/BRIEF.md
# Multi-Input Wake-Up Interrupt Router

This block watches a set of asynchronous wake-up inputs and turns each detected edge into a latched pending flag. The inputs are grouped in banks of sixteen channels. The default build has two banks, 32 channels in all. Each channel brings its input through a two-flop synchronizer. A per-channel polarity bit chooses whether a rising or a falling edge counts as a trigger. A trigger sets that channel's pending bit, and the bit stays set until software clears it.

Each bank owns its own group of four interrupt request lines. Every channel carries a 2-bit select field that picks one line of its bank's group. A request line is high while any channel routed to it is both pending and enabled. The request lines are level outputs.

Software reaches the block through a small word-wide register port. The pending register can only be set by writes. Clearing is done through a separate write-one-to-clear register. Because of this, a read-modify-write cycle in software cannot wipe out a trigger that hardware latched in between.

Top module: `wakeup_router`

## Requirements
- R1: After a synchronous active-low reset, every pending, enable, polarity and select bit is 0, and every request output is 0.
- R2: A channel with polarity 0 latches a rising input edge. An input change applied before clock edge k is synchronized at edges k and k+1, and the pending bit is set at edge k+2.
- R3: With polarity 1 a channel latches only falling edges; a rising edge leaves its pending bit at 0.
- R4: A pending bit stays set after its input returns to the idle level, until software clears it.
- R5: Writing the pending register (offset 0) sets every pending bit written as 1; bits written as 0 keep their value.
- R6: Writing the clear register (offset 1) clears every pending bit written as 1; bits written as 0 keep their value; reading offset 1 returns 0.
- R7: When hardware sets a pending bit in the same cycle that software clears it, the bit ends up set.
- R8: The select fields are 2 bits wide, eight to a word. Offset 4 holds channels 0..7 of the bank, and offset 5 holds channels 8..15. Channel j of a word sits in bits 2j+1:2j, so the highest channel is in bits 15:14. The fields read back as written.
- R9: In bank 0, select codes 0..3 route a channel to requests 0..3. In bank 1, the same codes route to requests 4..7. After reset, bank-0 channels drive request 0 and bank-1 channels drive request 4.
- R10: A request output is the OR of all channels that are pending, enabled (offset 2, 1 = enabled) and routed to it. A disabled channel keeps its pending bit latched but drives no request.
- R11: The address is {bank, offset[2:0]}. Offset 3 is polarity, and offsets 6 and 7 read 0. A read strobe registers the addressed word, which appears on the data output one cycle later and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wk_in | input | 32 | Asynchronous wake-up inputs, one per channel |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Register address {bank, offset} |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 8 | Level-sensitive interrupt request lines |

## Verification
The bench builds the block with its default parameters: two banks of sixteen channels, four request lines per bank, a 16-bit data word and two synchronizer stages. Two banks bring the offset routing of bank 1 (codes landing on requests 4..7) within reach. The 16-bit word makes both select words per bank necessary, so the top field in bits 15:14 and the bottom field in bits 1:0 can both be exercised. Two stages fix the trigger-to-pending latency at three edges. This lets the bench place a clear write on exactly the edge where hardware sets the same bit.

// File: rtl/wkup_pkg.sv
// Shared register offsets and address field widths for the wake-up router.
// Assumes each bank decodes a 3-bit offset inside its own address window.
package wkup_pkg;
    localparam int OFF_W    = 3;
    localparam int OFF_PEND = 0;
    localparam int OFF_CLR  = 1;
    localparam int OFF_EN   = 2;
    localparam int OFF_POL  = 3;
    localparam int OFF_SEL  = 4;

    typedef logic [OFF_W-1:0] reg_off_t;
endpackage

// File: rtl/wkup_edge.sv
// Synchronizes a vector of asynchronous wake-up pins and flags the chosen edge.
// Assumes STAGES >= 2. A polarity bit of 0 selects rising edges and 1 selects falling.
// det is combinational from the last synchronizer stage and its delayed copy.
module wkup_edge #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] pol,
    output logic [WIDTH-1:0] det
);
    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             last;
    logic [WIDTH-1:0]             synced;

    assign synced = chain[STAGES-1];

    // Shift pins through the synchronizer and keep one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= synced;
        end
    end

    // Pick rising or falling transitions per channel
    always_comb begin
        det = (synced & ~last & ~pol) | (~synced & last & pol);
    end
endmodule

// File: rtl/wkup_bank.sv
// One bank of wake-up channels: pending, enable, polarity and routing registers,
// the local read mux, and the OR-combining into the bank's request lines.
// Assumes CH == DW (one pending bit per data bit) and that 2-bit fields pack evenly.
module wkup_bank
    import wkup_pkg::*;
#(
    parameter int CH  = 16,
    parameter int REQ = 4,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CH-1:0]  det,
    input  logic           wr_stb,
    input  reg_off_t       off,
    input  logic [DW-1:0]  wr_data,
    output logic [CH-1:0]  pol,
    output logic [DW-1:0]  rd_word,
    output logic [REQ-1:0] irq
);
    localparam int SEL_W     = $clog2(REQ);
    localparam int PER_WORD  = DW / SEL_W;
    localparam int SEL_WORDS = CH / PER_WORD;

    logic [CH-1:0]             pend;
    logic [CH-1:0]             en;
    logic [CH-1:0][SEL_W-1:0]  sel;
    logic [CH-1:0]             set_mask;
    logic [CH-1:0]             clr_mask;
    logic [CH-1:0]             live;

    // Decode set and clear masks from the write strobe
    always_comb begin
        set_mask = (wr_stb && off == reg_off_t'(OFF_PEND)) ? wr_data[CH-1:0] : '0;
        clr_mask = (wr_stb && off == reg_off_t'(OFF_CLR))  ? wr_data[CH-1:0] : '0;
    end

    // Latch triggers and software sets; a set in the same cycle overrides a clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | det | set_mask;
    end

    // Hold enable and polarity words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= '0;
            pol <= '0;
        end else if (wr_stb) begin
            if (off == reg_off_t'(OFF_EN))  en  <= wr_data[CH-1:0];
            if (off == reg_off_t'(OFF_POL)) pol <= wr_data[CH-1:0];
        end
    end

    // One select word per group of PER_WORD channels
    for (genvar w = 0; w < SEL_WORDS; w++) begin : g_selw
        // Update the routing fields of this word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int j = 0; j < PER_WORD; j++) sel[w*PER_WORD+j] <= '0;
            end else if (wr_stb && off == reg_off_t'(OFF_SEL + w)) begin
                for (int j = 0; j < PER_WORD; j++)
                    sel[w*PER_WORD+j] <= wr_data[j*SEL_W +: SEL_W];
            end
        end
    end

    // Select the addressed word for the read port
    always_comb begin
        rd_word = '0;
        case (off)
            reg_off_t'(OFF_PEND): rd_word[CH-1:0] = pend;
            reg_off_t'(OFF_EN):   rd_word[CH-1:0] = en;
            reg_off_t'(OFF_POL):  rd_word[CH-1:0] = pol;
            default: begin
                for (int w = 0; w < SEL_WORDS; w++)
                    if (off == reg_off_t'(OFF_SEL + w))
                        for (int j = 0; j < PER_WORD; j++)
                            rd_word[j*SEL_W +: SEL_W] = sel[w*PER_WORD+j];
            end
        endcase
    end

    assign live = pend & en;

    // One OR tree per request line
    for (genvar r = 0; r < REQ; r++) begin : g_req
        logic [CH-1:0] hit;
        // Mark channels routed to this line
        always_comb begin
            for (int c = 0; c < CH; c++) hit[c] = live[c] && (sel[c] == SEL_W'(r));
        end
        assign irq[r] = |hit;
    end

    // R5
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((pend & $past(set_mask)) == $past(set_mask)));
    // R6
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((pend & $past(clr_mask & ~det & ~set_mask)) == '0));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|det) |=> ((pend & $past(det)) == $past(det)));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> (($past(pend) & ~pend) == '0));
    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |-> (irq == '0));
endmodule

// File: rtl/wakeup_router.sv
// Top of the wake-up interrupt router: one synchronizer/edge stage and one
// register bank per group of channels, a shared write decode and a registered read port.
// Assumes NUM_BANKS >= 2 so that the bank field of the address is at least one bit.
module wakeup_router
    import wkup_pkg::*;
#(
    parameter int NUM_BANKS    = 2,
    parameter int CH_PER_BANK  = 16,
    parameter int REQ_PER_BANK = 4,
    parameter int DATA_W       = 16,
    parameter int SYNC_STAGES  = 2,
    localparam int NUM_CH      = NUM_BANKS * CH_PER_BANK,
    localparam int NUM_REQ     = NUM_BANKS * REQ_PER_BANK,
    localparam int BANK_W      = $clog2(NUM_BANKS),
    localparam int ADDR_W      = BANK_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  wk_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_REQ-1:0] irq
);
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_word;
    logic [BANK_W-1:0]                bank_idx;
    reg_off_t                         off;

    assign bank_idx = addr[ADDR_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CH_PER_BANK-1:0] det;
        logic [CH_PER_BANK-1:0] pol;
        logic                   stb;

        assign stb = wr_en && (bank_idx == BANK_W'(b));

        wkup_edge #(
            .WIDTH  (CH_PER_BANK),
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (wk_in[b*CH_PER_BANK +: CH_PER_BANK]),
            .pol   (pol),
            .det   (det)
        );

        wkup_bank #(
            .CH  (CH_PER_BANK),
            .REQ (REQ_PER_BANK),
            .DW  (DATA_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .det     (det),
            .wr_stb  (stb),
            .off     (off),
            .wr_data (wr_data),
            .pol     (pol),
            .rd_word (bank_word[b]),
            .irq     (irq[b*REQ_PER_BANK +: REQ_PER_BANK])
        );
    end

    // Register the addressed word on a read strobe and hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= (int'(bank_idx) < NUM_BANKS) ? bank_word[bank_idx] : '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        (!rst_n) |=> (irq == '0 && rd_data == '0));
    // R6
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && off == reg_off_t'(OFF_CLR)) |=> (rd_data == '0));
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rd_data));
endmodule

// File: tb/wakeup_router_tb.sv
// Bench: a behavioural model advanced on every edge, compared on every falling edge,
// plus directed scenarios for each requirement and a random phase.
module wakeup_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wk_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit live    = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    wakeup_router u_dut (
        .clk(clk), .rst_n(rst_n), .wk_in(wk_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Behavioural model state
    logic [31:0] m_s1, m_s2, m_prev, m_pend, m_en, m_pol;
    int          m_sel [32];
    logic [15:0] m_rd;

    function automatic logic [15:0] m_read(input int a);
        int b = a / 8;
        int o = a % 8;
        logic [15:0] v = '0;
        case (o)
            0: v = m_pend[b*16 +: 16];
            2: v = m_en[b*16 +: 16];
            3: v = m_pol[b*16 +: 16];
            4, 5: for (int j = 0; j < 8; j++) v[2*j +: 2] = 2'(m_sel[b*16 + (o-4)*8 + j]);
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [7:0] m_irq();
        logic [7:0] r = '0;
        for (int c = 0; c < 32; c++)
            if (m_pend[c] && m_en[c]) r[(c/16)*4 + m_sel[c]] = 1'b1;
        return r;
    endfunction

    // Advance the model on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_en = '0; m_pol = '0; m_rd = '0;
            for (int c = 0; c < 32; c++) m_sel[c] = 0;
            live = 1;
        end else begin
            logic [31:0] trig;
            int b, o;
            trig = '0;
            for (int c = 0; c < 32; c++)
                trig[c] = m_pol[c] ? (!m_s2[c] && m_prev[c]) : (m_s2[c] && !m_prev[c]);
            if (rd_en) m_rd = m_read(int'(addr));
            b = int'(addr) / 8;
            o = int'(addr) % 8;
            if (wr_en) begin
                for (int j = 0; j < 16; j++) begin
                    if (o == 1 && wr_data[j]) m_pend[b*16+j] = 1'b0;
                    if (o == 0 && wr_data[j]) m_pend[b*16+j] = 1'b1;
                    if (o == 2) m_en[b*16+j]  = wr_data[j];
                    if (o == 3) m_pol[b*16+j] = wr_data[j];
                end
                if (o == 4 || o == 5)
                    for (int j = 0; j < 8; j++) m_sel[b*16 + (o-4)*8 + j] = int'(wr_data[2*j +: 2]);
            end
            m_pend = m_pend | trig;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = wk_in;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare the model with the outputs on every falling edge
    always @(negedge clk) begin
        if (live && !done) begin
            chk(irq === m_irq(), "R9 irq routing vs model", 32'(irq), 32'(m_irq()));
            chk(rd_data === m_rd, "R11 read data vs model", 32'(rd_data), 32'(m_rd));
        end
    end

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        idle(4);
        rst_n = 1'b1;
        // R1: all registers zero after reset
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk(v == 16'h0, "R1 register reset value", 32'(v), 0);
        end
        chk(irq == 8'h0, "R1 irq after reset", 32'(irq), 0);

        wr(2, 16'hFFFF);
        wr(10, 16'hFFFF);

        // R2: rising edge latency, routed to request 0 by default
        @(negedge clk); wk_in[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(irq[0] == 1'b0, "R2 no pending before third edge", 32'(irq), 0);
        @(negedge clk);
        chk(irq[0] == 1'b1, "R2 pending on third edge", 32'(irq), 1);

        // R4: pending holds after input returns low
        wk_in[3] = 1'b0;
        idle(5);
        rd(0, v);
        chk(v[3] == 1'b1, "R4 pending held", 32'(v), 32'h8);

        // R6: clear with 0 has no effect, with 1 clears, clear reads 0
        wr(1, 16'h0000);
        rd(0, v);
        chk(v[3] == 1'b1, "R6 zero clear ignored", 32'(v), 32'h8);
        wr(1, 16'h0008);
        rd(0, v);
        chk(v == 16'h0, "R6 one clears", 32'(v), 0);
        rd(1, v);
        chk(v == 16'h0, "R6 clear register reads zero", 32'(v), 0);

        // R3: falling-edge polarity
        wr(3, 16'h0020);
        @(negedge clk); wk_in[5] = 1'b1;
        idle(5);
        rd(0, v);
        chk(v[5] == 1'b0, "R3 rising ignored with polarity 1", 32'(v), 0);
        wk_in[5] = 1'b0;
        idle(5);
        rd(0, v);
        chk(v[5] == 1'b1, "R3 falling latched", 32'(v), 32'h20);

        // R7: hardware set and software clear on the same edge
        @(negedge clk); wk_in[9] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr_en = 1'b1; addr = 4'd1; wr_data = 16'h0200;
        @(negedge clk);
        wr_en = 1'b0;
        rd(0, v);
        chk(v[9] == 1'b1, "R7 set wins over clear", 32'(v), 32'h200);

        // R5: software set in bank 1, zero write ignored
        wr(8, 16'h0100);
        chk(irq[4] == 1'b1, "R5 set drives request 4", 32'(irq), 32'h10);
        wr(8, 16'h0000);
        rd(8, v);
        chk(v == 16'h0100, "R5 zero write ignored", 32'(v), 32'h100);

        // R8 R9: routing fields in both words and both banks
        wr(13, 16'h0002);
        chk(irq[6] == 1'b1 && irq[4] == 1'b0, "R9 bank 1 code 2 -> request 6", 32'(irq), 32'h40);
        rd(13, v);
        chk(v == 16'h0002, "R8 low field readback", 32'(v), 2);
        wr(5, 16'hC000);
        wr(0, 16'h8000);
        chk(irq[3] == 1'b1, "R9 bank 0 code 3 -> request 3", 32'(irq), 32'h8);
        rd(5, v);
        chk(v == 16'hC000, "R8 top field readback", 32'(v), 32'hC000);

        // R10: disabling a channel drops its request, pending stays
        wr(2, 16'h7FFF);
        chk(irq[3] == 1'b0, "R10 disabled channel quiet", 32'(irq), 0);
        rd(0, v);
        chk(v[15] == 1'b1, "R10 pending kept while disabled", 32'(v), 32'h8000);

        // R11: unused offsets read zero
        rd(6, v);
        chk(v == 16'h0, "R11 offset 6 reads zero", 32'(v), 0);

        // Random phase checked against the model each cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) wk_in = wk_in ^ (32'h1 << $urandom_range(0, 31));
            wr_en   = ($urandom_range(0, 5) == 0);
            rd_en   = ($urandom_range(0, 2) == 0);
            addr    = 4'($urandom_range(0, 15));
            wr_data = 16'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        idle(4);
        finish_run();
    end
endmodule